// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits next to a small 16-bit processor core and carries out the hardware part of taking an interrupt. It watches two request lines, a non-maskable one and a maskable one, and acts only when the core reports that an instruction has finished. A maskable request also needs the enable bit of the core's flags to be set. Before any memory traffic, a maskable entry runs an acknowledge handshake to get an 8-bit interrupt type from an external controller. A non-maskable entry skips the handshake and always uses type 2.

The sequencer saves the return context on the stack. It writes three words through a word-wide memory port that waits for a ready signal. It then reads the handler's instruction pointer and code segment from the vector table. At the end it pulses a completion strobe while it presents the new code segment, instruction pointer, stack pointer and the edited flags. The core loads all of these in that same cycle. At the moment of the instruction-boundary pulse, the core must present its flags, code segment, instruction pointer, stack pointer and stack segment. The sequencer copies them then.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `inta_n` is high, `mem_req` is low and `entry_done` is low, and the block stays idle until a request is taken at an instruction boundary.
- R2: A sequence begins only in a cycle where `insn_done` is high. Requests that are pending while `insn_done` stays low cause no acknowledge, no memory access and no completion.
- R3: A maskable request on `intr_req` is taken only when bit 9 of `core_flags` (interrupt enable) is 1. When that bit is 0, an `insn_done` pulse produces no acknowledge, no memory access and no completion.
- R4: The non-maskable input is detected on its rising edge and held until it is serviced. It always uses type 2, and it gives exactly one entry per rising edge, even while the line stays high.
- R5: If a pending non-maskable request and an enabled maskable request meet at the same boundary, the non-maskable one is serviced, and `inta_n` stays high during that entry.
- R6: A maskable entry drives `inta_n` low for exactly two single-cycle pulses with one high cycle between them. The type is taken from `mem_rdata[7:0]` during the second low cycle only. `mem_req` is low while `inta_n` is low.
- R7: Three words are pushed in this order: flags, code segment, instruction pointer. Before each write the stack pointer drops by 2, with 16-bit wraparound. Each write goes to physical address `(core_ss << 4) + SP`, formed as a 20-bit address.
- R8: The new instruction pointer is read from byte address type×4 and the new code segment from type×4+2. For the non-maskable line these are 0x00008 and 0x0000A.
- R9: Every memory access holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ready` is high at a clock edge, and each access ends at the first such edge.
- R10: `entry_done` is high for exactly one cycle at the end of a sequence. In that cycle `new_cs` and `new_ip` carry the words read, `new_sp` is the entry stack pointer minus 6, and `new_flags` equals the saved flags with bits 9 and 8 cleared and all other bits kept.
- R11: A non-maskable rising edge that arrives during a maskable entry stays pending and is serviced at the next `insn_done` pulse after that entry completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| nmi_req | input | 1 | Non-maskable request, rising-edge sensitive |
| intr_req | input | 1 | Maskable request, level sensitive |
| insn_done | input | 1 | Instruction boundary pulse from the core |
| core_flags | input | 16 | Core flags word (bit 9 enable, bit 8 trap) |
| core_cs | input | 16 | Return code segment |
| core_ip | input | 16 | Return instruction pointer |
| core_sp | input | 16 | Current stack pointer |
| core_ss | input | 16 | Current stack segment |
| inta_n | output | 1 | Active-low interrupt acknowledge |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, also carries the type byte during acknowledge |
| mem_ready | input | 1 | Transfer complete, active high |
| entry_done | output | 1 | One-cycle completion strobe |
| new_cs | output | 16 | Handler code segment |
| new_ip | output | 16 | Handler instruction pointer |
| new_sp | output | 16 | Stack pointer after the three pushes |
| new_flags | output | 16 | Flags with enable and trap cleared |

## Verification
The bench uses the default parameters: a 16-bit word, a 20-bit physical address, an 8-bit type code, and non-maskable type 2 with flag bits 9 and 8. With a 4-bit segment shift, a stack pointer of zero reaches the wraparound corner near the top of a segment. An 8-bit type puts vectors such as 0x84 and 0x100 in reach. The bench memory model can add several wait cycles per access, which makes the exact number of request cycles observable. Its first acknowledge pulse returns a different byte from the second, so a type captured on the wrong pulse shows up as the wrong vector address.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACK1,
    ST_GAP,
    ST_ACK2,
    ST_PSH_FL,
    ST_PSH_CS,
    ST_PSH_IP,
    ST_VEC_IP,
    ST_VEC_CS,
    ST_DONE
  } entry_st_e;

endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic intr_in,
  input  logic intr_en,
  input  logic boundary,
  input  logic idle,
  output logic start,
  output logic start_nmi
);

  logic nmi_q, nmi_pend;
  logic nmi_edge;
  logic nmi_q_d, nmi_pend_d;

  always_comb begin
    nmi_edge   = nmi_in & ~nmi_q;
    start      = boundary & idle & (nmi_pend | (intr_in & intr_en));
    start_nmi  = start & nmi_pend;
    nmi_q_d    = nmi_in;
    nmi_pend_d = (nmi_pend & ~start_nmi) | nmi_edge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi_q_d;
      nmi_pend <= nmi_pend_d;
    end
  end

  // R11: a pending non-maskable request is only dropped when it is serviced
  assert_nmi_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !start_nmi) |=> nmi_pend);

  // R2: nothing starts away from an instruction boundary
  assert_start_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> boundary);

endmodule

// File: rtl/irq_bus_mux.sv
module irq_bus_mux
  import irq_entry_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 20,
  parameter int TYPE_W = 8
) (
  input  entry_st_e           state,
  input  logic [DATA_W-1:0]   ss_r,
  input  logic [DATA_W-1:0]   sp_r,
  input  logic [TYPE_W-1:0]   vtype,
  input  logic [DATA_W-1:0]   fl_r,
  input  logic [DATA_W-1:0]   cs_r,
  input  logic [DATA_W-1:0]   ip_r,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata
);

  localparam int SEG_SH = ADDR_W - DATA_W;
  localparam int VEC_W  = TYPE_W + 2;

  logic [DATA_W-1:0] sp_dec;
  logic [ADDR_W-1:0] push_addr;
  logic [ADDR_W-1:0] vec_base;

  always_comb begin
    sp_dec    = sp_r - DATA_W'(2);
    push_addr = {ss_r, {SEG_SH{1'b0}}} + {{SEG_SH{1'b0}}, sp_dec};
    vec_base  = {{(ADDR_W-VEC_W){1'b0}}, vtype, 2'b00};
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      ST_PSH_FL: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = push_addr; mem_wdata = fl_r;
      end
      ST_PSH_CS: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = push_addr; mem_wdata = cs_r;
      end
      ST_PSH_IP: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = push_addr; mem_wdata = ip_r;
      end
      ST_VEC_IP: begin
        mem_req = 1'b1; mem_addr = vec_base;
      end
      ST_VEC_CS: begin
        mem_req = 1'b1; mem_addr = vec_base + ADDR_W'(2);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int TYPE_W   = 8,
  parameter int NMI_TYPE = 2,
  parameter int IF_BIT   = 9,
  parameter int TF_BIT   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                start_nmi,
  input  logic [DATA_W-1:0]   flags_in,
  input  logic [DATA_W-1:0]   cs_in,
  input  logic [DATA_W-1:0]   ip_in,
  input  logic [DATA_W-1:0]   sp_in,
  input  logic [DATA_W-1:0]   ss_in,
  input  logic [DATA_W-1:0]   rdata,
  input  logic                acc_done,
  output entry_st_e           state,
  output logic [TYPE_W-1:0]   vtype,
  output logic [DATA_W-1:0]   sp_r,
  output logic [DATA_W-1:0]   ss_r,
  output logic [DATA_W-1:0]   fl_r,
  output logic [DATA_W-1:0]   cs_r,
  output logic [DATA_W-1:0]   ip_r,
  output logic                idle,
  output logic                inta_n,
  output logic                done,
  output logic [DATA_W-1:0]   new_cs,
  output logic [DATA_W-1:0]   new_ip,
  output logic [DATA_W-1:0]   new_flags
);

  localparam logic [DATA_W-1:0] CLR_MASK =
    ~((DATA_W'(1) << IF_BIT) | (DATA_W'(1) << TF_BIT));
  localparam logic [TYPE_W-1:0] NMI_VEC = TYPE_W'(NMI_TYPE);

  entry_st_e         state_d;
  logic              cap_en, type_en, type_nmi, sp_en, nip_en, ncs_en;
  logic [TYPE_W-1:0] vtype_d;
  logic [DATA_W-1:0] sp_d;
  logic [DATA_W-1:0] nip_r, ncs_r;
  logic              is_push;

  // next-state and enables
  always_comb begin
    state_d = state;
    is_push = (state == ST_PSH_FL) || (state == ST_PSH_CS) || (state == ST_PSH_IP);
    case (state)
      ST_IDLE:   if (start) state_d = start_nmi ? ST_PSH_FL : ST_ACK1;
      ST_ACK1:   state_d = ST_GAP;
      ST_GAP:    state_d = ST_ACK2;
      ST_ACK2:   state_d = ST_PSH_FL;
      ST_PSH_FL: if (acc_done) state_d = ST_PSH_CS;
      ST_PSH_CS: if (acc_done) state_d = ST_PSH_IP;
      ST_PSH_IP: if (acc_done) state_d = ST_VEC_IP;
      ST_VEC_IP: if (acc_done) state_d = ST_VEC_CS;
      ST_VEC_CS: if (acc_done) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
    cap_en   = (state == ST_IDLE) && start;
    type_nmi = cap_en && start_nmi;
    type_en  = type_nmi || (state == ST_ACK2);
    vtype_d  = type_nmi ? NMI_VEC : rdata[TYPE_W-1:0];
    sp_en    = cap_en || (is_push && acc_done);
    sp_d     = cap_en ? sp_in : (sp_r - DATA_W'(2));
    nip_en   = (state == ST_VEC_IP) && acc_done;
    ncs_en   = (state == ST_VEC_CS) && acc_done;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      vtype <= '0;
      sp_r  <= '0;
      ss_r  <= '0;
      fl_r  <= '0;
      cs_r  <= '0;
      ip_r  <= '0;
      nip_r <= '0;
      ncs_r <= '0;
    end else begin
      state <= state_d;
      if (type_en) vtype <= vtype_d;
      if (sp_en)   sp_r  <= sp_d;
      if (cap_en) begin
        ss_r <= ss_in;
        fl_r <= flags_in;
        cs_r <= cs_in;
        ip_r <= ip_in;
      end
      if (nip_en) nip_r <= rdata;
      if (ncs_en) ncs_r <= rdata;
    end
  end

  always_comb begin
    idle      = (state == ST_IDLE);
    inta_n    = !((state == ST_ACK1) || (state == ST_ACK2));
    done      = (state == ST_DONE);
    new_cs    = ncs_r;
    new_ip    = nip_r;
    new_flags = fl_r & CLR_MASK;
  end

  // R6: each acknowledge low phase lasts one cycle
  assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inta_n) |=> inta_n);

  // R5: a non-maskable start never leads into an acknowledge cycle
  assert_nmi_no_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start && start_nmi) |=> inta_n);

  // R10: the completion strobe lasts exactly one cycle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 20,
  parameter int TYPE_W   = 8,
  parameter int NMI_TYPE = 2,
  parameter int IF_BIT   = 9,
  parameter int TF_BIT   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_req,
  input  logic              intr_req,
  input  logic              insn_done,
  input  logic [DATA_W-1:0] core_flags,
  input  logic [DATA_W-1:0] core_cs,
  input  logic [DATA_W-1:0] core_ip,
  input  logic [DATA_W-1:0] core_sp,
  input  logic [DATA_W-1:0] core_ss,
  output logic              inta_n,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              entry_done,
  output logic [DATA_W-1:0] new_cs,
  output logic [DATA_W-1:0] new_ip,
  output logic [DATA_W-1:0] new_sp,
  output logic [DATA_W-1:0] new_flags
);

  logic [1:0]        rst_pipe;
  logic              rst_s;
  logic              start, start_nmi, idle, acc_done;
  entry_st_e         state;
  logic [TYPE_W-1:0] vtype;
  logic [DATA_W-1:0] sp_r, ss_r, fl_r, cs_r, ip_r;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s    = rst_pipe[1];
  assign acc_done = mem_req & mem_ready;
  assign new_sp   = sp_r;

  irq_req_latch u_req (
    .clk       (clk),
    .rst_n     (rst_s),
    .nmi_in    (nmi_req),
    .intr_in   (intr_req),
    .intr_en   (core_flags[IF_BIT]),
    .boundary  (insn_done),
    .idle      (idle),
    .start     (start),
    .start_nmi (start_nmi)
  );

  irq_entry_ctrl #(
    .DATA_W   (DATA_W),
    .TYPE_W   (TYPE_W),
    .NMI_TYPE (NMI_TYPE),
    .IF_BIT   (IF_BIT),
    .TF_BIT   (TF_BIT)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s),
    .start     (start),
    .start_nmi (start_nmi),
    .flags_in  (core_flags),
    .cs_in     (core_cs),
    .ip_in     (core_ip),
    .sp_in     (core_sp),
    .ss_in     (core_ss),
    .rdata     (mem_rdata),
    .acc_done  (acc_done),
    .state     (state),
    .vtype     (vtype),
    .sp_r      (sp_r),
    .ss_r      (ss_r),
    .fl_r      (fl_r),
    .cs_r      (cs_r),
    .ip_r      (ip_r),
    .idle      (idle),
    .inta_n    (inta_n),
    .done      (entry_done),
    .new_cs    (new_cs),
    .new_ip    (new_ip),
    .new_flags (new_flags)
  );

  irq_bus_mux #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .TYPE_W (TYPE_W)
  ) u_bus (
    .state     (state),
    .ss_r      (ss_r),
    .sp_r      (sp_r),
    .vtype     (vtype),
    .fl_r      (fl_r),
    .cs_r      (cs_r),
    .ip_r      (ip_r),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  // R9: an access waiting for ready keeps every bus field steady
  assert_bus_hold_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (mem_req && !mem_ready) |=>
      (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  // R6: acknowledge and memory traffic never overlap
  assert_ack_no_mem_R6: assert property (@(posedge clk) disable iff (!rst_s)
    !inta_n |-> !mem_req);

endmodule

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        nmi_req, intr_req, insn_done;
  logic [15:0] core_flags, core_cs, core_ip, core_sp, core_ss;
  logic        inta_n, mem_req, mem_we, mem_ready, entry_done;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [15:0] new_cs, new_ip, new_sp, new_flags;

  int n_chk = 0;
  int n_bad = 0;

  // bench memory and acknowledge model
  int          waitn = 0;
  int          wcnt  = 0;
  logic        clr   = 1'b0;
  logic [7:0]  first_byte, type_byte;
  int          nw, nr, ack_lows, ack_falls, done_cnt, req_cycles;
  logic        inta_q;
  logic [19:0] wa [8];
  logic [15:0] wd [8];
  logic [19:0] ra [8];
  logic [15:0] cap_cs, cap_ip, cap_sp, cap_fl;

  always #10 clk = ~clk;

  function automatic logic [15:0] vec(input logic [19:0] a);
    return a[15:0] ^ 16'hA5C3;
  endfunction

  assign mem_ready = mem_req && (wcnt >= waitn);
  assign mem_rdata = !inta_n ? {8'h00, (ack_lows == 0) ? first_byte : type_byte}
                             : vec(mem_addr);

  irq_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .intr_req(intr_req),
    .insn_done(insn_done), .core_flags(core_flags), .core_cs(core_cs),
    .core_ip(core_ip), .core_sp(core_sp), .core_ss(core_ss),
    .inta_n(inta_n), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .entry_done(entry_done), .new_cs(new_cs), .new_ip(new_ip),
    .new_sp(new_sp), .new_flags(new_flags)
  );

  always @(posedge clk) begin
    if (clr) begin
      nw = 0; nr = 0; ack_lows = 0; ack_falls = 0; done_cnt = 0;
      req_cycles = 0; wcnt = 0; inta_q = 1'b1;
    end else begin
      if (mem_req) req_cycles++;
      if (mem_req && mem_ready) begin
        if (mem_we) begin
          if (nw < 8) begin wa[nw] = mem_addr; wd[nw] = mem_wdata; end
          nw++;
        end else begin
          if (nr < 8) ra[nr] = mem_addr;
          nr++;
        end
        wcnt = 0;
      end else if (mem_req) wcnt++;
      if (!inta_n) ack_lows++;
      if (inta_q && !inta_n) ack_falls++;
      inta_q = inta_n;
      if (entry_done) begin
        done_cnt++;
        cap_cs = new_cs; cap_ip = new_ip; cap_sp = new_sp; cap_fl = new_flags;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic boundary();
    @(negedge clk) insn_done = 1'b1;
    @(negedge clk) insn_done = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 inta_n", 32'(inta_n), 32'd1);
    check("R1 mem_req", 32'(mem_req), 32'd0);
    check("R1 entry_done", 32'(entry_done), 32'd0);
  endtask

  task automatic t_nmi_basic();
    waitn = 0;
    core_flags = 16'h0345; core_cs = 16'h1234; core_ip = 16'h5678;
    core_sp = 16'h0100; core_ss = 16'h2000;
    clear_logs();
    @(negedge clk) nmi_req = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 no access without boundary", 32'(req_cycles), 32'd0);
    check("R2 no done without boundary", 32'(done_cnt), 32'd0);
    boundary();
    repeat (30) @(negedge clk);
    check("R10 done count", 32'(done_cnt), 32'd1);
    check("R4 no acknowledge", 32'(ack_lows), 32'd0);
    check("R7 push count", 32'(nw), 32'd3);
    check("R7 flags addr", 32'(wa[0]), 32'h200FE);
    check("R7 flags data", 32'(wd[0]), 32'h0345);
    check("R7 cs addr", 32'(wa[1]), 32'h200FC);
    check("R7 cs data", 32'(wd[1]), 32'h1234);
    check("R7 ip addr", 32'(wa[2]), 32'h200FA);
    check("R7 ip data", 32'(wd[2]), 32'h5678);
    check("R8 ip vector addr", 32'(ra[0]), 32'h00008);
    check("R8 cs vector addr", 32'(ra[1]), 32'h0000A);
    check("R10 new_ip", 32'(cap_ip), 32'(vec(20'h00008)));
    check("R10 new_cs", 32'(cap_cs), 32'(vec(20'h0000A)));
    check("R10 new_sp", 32'(cap_sp), 32'h00FA);
    check("R10 new_flags", 32'(cap_fl), 32'h0045);
    check("R10 done low after", 32'(entry_done), 32'd0);
    // line still high: no second entry
    clear_logs();
    boundary();
    repeat (20) @(negedge clk);
    check("R4 one entry per edge", 32'(done_cnt), 32'd0);
    nmi_req = 1'b0;
  endtask

  task automatic t_intr_masked();
    waitn = 0;
    core_flags = 16'h0100;
    clear_logs();
    @(negedge clk) intr_req = 1'b1;
    boundary();
    repeat (20) @(negedge clk);
    check("R3 masked no ack", 32'(ack_lows), 32'd0);
    check("R3 masked no access", 32'(req_cycles), 32'd0);
    check("R3 masked no done", 32'(done_cnt), 32'd0);
    intr_req = 1'b0;
  endtask

  task automatic t_intr_ok();
    waitn = 2;
    core_flags = 16'h03C1; core_cs = 16'hBEEF; core_ip = 16'h0F0F;
    core_sp = 16'h0000; core_ss = 16'h1000;
    first_byte = 8'h55; type_byte = 8'h21;
    clear_logs();
    @(negedge clk) intr_req = 1'b1;
    boundary();
    repeat (40) @(negedge clk);
    intr_req = 1'b0;
    check("R6 ack low cycles", 32'(ack_lows), 32'd2);
    check("R6 ack pulses", 32'(ack_falls), 32'd2);
    check("R7 wrap flags addr", 32'(wa[0]), 32'h1FFFE);
    check("R7 wrap cs addr", 32'(wa[1]), 32'h1FFFC);
    check("R7 wrap ip addr", 32'(wa[2]), 32'h1FFFA);
    check("R6 R8 ip vector from second byte", 32'(ra[0]), 32'h00084);
    check("R8 cs vector", 32'(ra[1]), 32'h00086);
    check("R9 request cycles with waits", 32'(req_cycles), 32'd15);
    check("R9 push data under waits", 32'(wd[1]), 32'hBEEF);
    check("R10 new_sp wrap", 32'(cap_sp), 32'hFFFA);
    check("R10 new_flags", 32'(cap_fl), 32'h00C1);
    check("R10 new_ip", 32'(cap_ip), 32'(vec(20'h00084)));
  endtask

  task automatic t_priority();
    waitn = 1;
    core_flags = 16'h0200; core_sp = 16'h0200; core_ss = 16'h0000;
    first_byte = 8'h11; type_byte = 8'h33;
    clear_logs();
    @(negedge clk) begin nmi_req = 1'b1; intr_req = 1'b1; end
    repeat (2) @(negedge clk);
    boundary();
    repeat (30) @(negedge clk);
    intr_req = 1'b0; nmi_req = 1'b0;
    check("R5 no ack when both", 32'(ack_lows), 32'd0);
    check("R5 type 2 vector", 32'(ra[0]), 32'h00008);
    check("R5 single entry", 32'(done_cnt), 32'd1);
  endtask

  task automatic t_nmi_during();
    waitn = 0;
    core_flags = 16'h0200; core_sp = 16'h0400; core_ss = 16'h0010;
    first_byte = 8'h00; type_byte = 8'h40;
    clear_logs();
    @(negedge clk) intr_req = 1'b1;
    boundary();
    while (!mem_req) @(negedge clk);
    nmi_req = 1'b1;
    repeat (30) @(negedge clk);
    intr_req = 1'b0;
    check("R11 maskable entry completes", 32'(done_cnt), 32'd1);
    check("R11 maskable vector", 32'(ra[0]), 32'h00100);
    clear_logs();
    boundary();
    repeat (30) @(negedge clk);
    check("R11 held nmi serviced", 32'(done_cnt), 32'd1);
    check("R11 held nmi vector", 32'(ra[0]), 32'h00008);
    nmi_req = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; nmi_req = 1'b0; intr_req = 1'b0; insn_done = 1'b0;
    core_flags = '0; core_cs = '0; core_ip = '0; core_sp = '0; core_ss = '0;
    first_byte = '0; type_byte = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_nmi_basic();
    t_intr_masked();
    t_intr_ok();
    t_priority();
    t_nmi_during();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule